// File: doc/BRIEF.md
# Transmit Holding Queue with Mode-Dependent Trigger

This block is the transmit-side holding queue of a serial port. The host writes bytes into it and a serializer pulls bytes out of it. Its usable depth is chosen at run time: one entry in single-byte mode, and 16 or 128 entries once queueing is switched on. The choice depends on a control byte written by the host, a static compatibility-mode input and an enhanced-feature flag.

The block reports an occupancy count, a full flag and an empty flag. It raises a transmit-request interrupt while the occupancy sits below the active threshold. That threshold is 1 in most configurations. It is taken from a four-entry table in the 650-style enhanced configuration with request mode 1. In the 950-style configuration it comes from a separately written 7-bit threshold register. A flush command in the control byte empties the queue and clears itself once the empty has been done.

Top module: `tx_hold_queue`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, `ctlRdData` is 0 and `irq` is 0 while `irqEn` is 0. The queue starts in single-byte mode.
- R2: When control bit 0 (queue enable) is 0, the depth is 1: a single accepted write sets `full`.
- R3: A write presented while `full` is 1 is dropped. `level` and the stored bytes stay as they were.
- R4: With the queue enabled and `enhanced` low, the depth is 16, except in the case given by R5.
- R5: With `mode` = 3 (750-style) and `enhanced` low, control bit 5 selects depth 128 when 1 and depth 16 when 0. A write changes that bit only while `dlabSet` is 1; otherwise the bit keeps its old value.
- R6: With `enhanced` high and the queue enabled, the depth is 128.
- R7: Writing control bit 2 as 1 empties the queue. Readback bit 2 of `ctlRdData` is 1 in the cycle after the write and 0 once the queue has been emptied, one cycle later.
- R8: With `mode` = 2 (650-style), `enhanced` high, control bit 3 (request mode) at 1 and the queue enabled, control bits 5:4 select a threshold of 16, 32, 64 or 112 for the values 0, 1, 2 or 3.
- R9: In every configuration not covered by R8 or R10, the threshold is 1.
- R10: With `mode` = 4 (950-style), `anyTrigEn` high and the queue enabled, the threshold is the value last written through `trigRegWr`/`trigRegData`, and control bits 5:4 are ignored.
- R11: `irq` is 1 exactly when `irqEn` is 1 and `level` is below the active threshold.
- R12: A push and a pop accepted in the same cycle leave `level` unchanged. Bytes leave in the order they were written.
- R13: A control write that changes the effective depth empties the queue, with the same timing as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Compatibility mode: 0=450, 1=550, 2=650, 3=750, 4=950 style |
| enhanced | input | 1 | Enhanced-feature flag |
| dlabSet | input | 1 | Divisor-latch access bit; gates control bit 5 in mode 3 |
| anyTrigEn | input | 1 | Use the programmable threshold register (mode 4) |
| irqEn | input | 1 | Transmit interrupt enable |
| ctlWrEn | input | 1 | Control byte write strobe |
| ctlWrData | input | 8 | Control byte: bit0 enable, bit2 flush, bit3 request mode, bits5:4 threshold/depth |
| ctlRdData | output | 8 | Control readback: bit0 enable, bit2 flush pending, bit3 request mode, bits5:4 field |
| trigRegWr | input | 1 | Threshold register write strobe |
| trigRegData | input | 7 | Threshold register value |
| wrValid | input | 1 | Host byte write |
| wrData | input | 8 | Host byte |
| popReq | input | 1 | Serializer takes the head byte |
| popData | output | 8 | Head byte, valid while `empty` is 0 |
| level | output | 8 | Occupancy count |
| full | output | 1 | Occupancy has reached the effective depth |
| empty | output | 1 | Occupancy is zero |
| irq | output | 1 | Transmit request interrupt |

## Verification
The main function is driven through a vector table. Each row sets the mode, the enhanced flag, the control byte, the latch-access bit and the threshold register, then fills the queue one byte at a time until it is full. The level at which `irq` first drops gives the threshold in force, and the final level gives the depth, so each row tells one table entry or gating condition apart from its neighbours. Examples are request mode 1 against request mode 0, 750-style depth with and without the latch-access bit, and the programmable threshold against the table field. Directed tests cover overflow discard with data order, simultaneous push and pop, flush self-clearing and flushing on a depth change.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [2:0] {
    MODE_450 = 3'd0,
    MODE_550 = 3'd1,
    MODE_650 = 3'd2,
    MODE_750 = 3'd3,
    MODE_950 = 3'd4
  } compatMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txqStrobe_t;

  // control byte bit positions
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_FLUSH_BIT = 2;
  localparam int CTL_REQ_BIT   = 3;
  localparam int CTL_FLD_LO    = 4;
  localparam int CTL_FLD_HI    = 5;

  // 650-style threshold table
  function automatic logic [7:0] trig650(input logic [1:0] sel);
    case (sel)
      2'd0:    trig650 = 8'd16;
      2'd1:    trig650 = 8'd32;
      2'd2:    trig650 = 8'd64;
      default: trig650 = 8'd112;
    endcase
  endfunction

endpackage

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 128
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  txqStrobe_t                           strobe,
  input  logic [DATA_W-1:0]                    wrData,
  output logic [DATA_W-1:0]                    headData,
  output logic [$clog2(MAX_DEPTH+1)-1:0]       count
);

  localparam int PTR_W = $clog2(MAX_DEPTH);
  localparam int LVL_W = $clog2(MAX_DEPTH+1);

  logic [DATA_W-1:0] store [MAX_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + LVL_W'(1);
        2'b01:   count <= count - LVL_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (count == '0));

  // R12
  pushpop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop && !strobe.flush) |=> $stable(count));

endmodule

// File: rtl/txq_control.sv
module txq_control
  import txq_pkg::*;
#(
  parameter int MAX_DEPTH  = 128,
  parameter int MID_DEPTH  = 16,
  parameter int BYTE_DEPTH = 1,
  parameter int TRIG_W     = 7
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [2:0]                       mode,
  input  logic                             enhanced,
  input  logic                             dlabSet,
  input  logic                             anyTrigEn,
  input  logic                             irqEn,
  input  logic                             ctlWrEn,
  input  logic [7:0]                       ctlWrData,
  output logic [7:0]                       ctlRdData,
  input  logic                             trigRegWr,
  input  logic [TRIG_W-1:0]                trigRegData,
  input  logic                             wrValid,
  input  logic                             popReq,
  input  logic [$clog2(MAX_DEPTH+1)-1:0]   level,
  output txqStrobe_t                       strobe,
  output logic                             full,
  output logic                             empty,
  output logic                             irq
);

  localparam int LVL_W = $clog2(MAX_DEPTH+1);

  compatMode_e      modeSel;
  logic             queueEn;
  logic             reqMode;
  logic [1:0]       trigField;
  logic             flushPend;
  logic [TRIG_W-1:0] trigReg;

  logic [1:0]       nextField;
  logic [LVL_W-1:0] curDepth;
  logic [LVL_W-1:0] nextDepth;
  logic [LVL_W-1:0] threshold;
  logic             bitLocked;

  assign modeSel   = compatMode_e'(mode);
  assign bitLocked = (modeSel == MODE_750) && !enhanced && !dlabSet;

  function automatic logic [LVL_W-1:0] depthFor(
      input logic en, input logic deepBit, input logic enh, input compatMode_e m);
    if (!en)                                  depthFor = LVL_W'(BYTE_DEPTH);
    else if (enh)                             depthFor = LVL_W'(MAX_DEPTH);
    else if (m == MODE_750 && deepBit)        depthFor = LVL_W'(MAX_DEPTH);
    else                                      depthFor = LVL_W'(MID_DEPTH);
  endfunction

  always_comb begin
    nextField = ctlWrData[CTL_FLD_HI:CTL_FLD_LO];
    if (bitLocked) nextField[1] = trigField[1];
    curDepth  = depthFor(queueEn, trigField[1], enhanced, modeSel);
    nextDepth = depthFor(ctlWrData[CTL_EN_BIT], nextField[1], enhanced, modeSel);
  end

  // control register and self-clearing flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      queueEn   <= 1'b0;
      reqMode   <= 1'b0;
      trigField <= 2'b00;
      flushPend <= 1'b0;
    end else if (ctlWrEn) begin
      queueEn   <= ctlWrData[CTL_EN_BIT];
      reqMode   <= ctlWrData[CTL_REQ_BIT];
      trigField <= nextField;
      flushPend <= ctlWrData[CTL_FLUSH_BIT] || (nextDepth != curDepth);
    end else begin
      flushPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          trigReg <= '0;
    else if (trigRegWr) trigReg <= trigRegData;
  end

  // active threshold
  always_comb begin
    if (modeSel == MODE_950 && anyTrigEn && queueEn)
      threshold = LVL_W'(trigReg);
    else if (modeSel == MODE_650 && enhanced && reqMode && queueEn)
      threshold = LVL_W'(trig650(trigField));
    else
      threshold = LVL_W'(1);
  end

  assign full  = (level >= curDepth);
  assign empty = (level == '0);
  assign irq   = irqEn && (level < threshold);

  assign strobe.flush = flushPend;
  assign strobe.push  = wrValid && !full && !flushPend;
  assign strobe.pop   = popReq && !empty && !flushPend;

  assign ctlRdData = {2'b00, trigField, reqMode, flushPend, 1'b0, queueEn};

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flushPend |-> (level <= curDepth));

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrValid && !popReq && !flushPend && !ctlWrEn) |=> (level == $past(level)));

  // R7
  flush_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushPend && !ctlWrEn) |=> !flushPend);

  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn) |-> !irq);

endmodule

// File: rtl/tx_hold_queue.sv
module tx_hold_queue
  import txq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 128,
  parameter int MID_DEPTH = 16,
  parameter int TRIG_W    = 7
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [2:0]                         mode,
  input  logic                               enhanced,
  input  logic                               dlabSet,
  input  logic                               anyTrigEn,
  input  logic                               irqEn,
  input  logic                               ctlWrEn,
  input  logic [7:0]                         ctlWrData,
  output logic [7:0]                         ctlRdData,
  input  logic                               trigRegWr,
  input  logic [TRIG_W-1:0]                  trigRegData,
  input  logic                               wrValid,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               popReq,
  output logic [DATA_W-1:0]                  popData,
  output logic [$clog2(MAX_DEPTH+1)-1:0]     level,
  output logic                               full,
  output logic                               empty,
  output logic                               irq
);

  txqStrobe_t strobe;

  txq_control #(
    .MAX_DEPTH (MAX_DEPTH),
    .MID_DEPTH (MID_DEPTH),
    .BYTE_DEPTH(1),
    .TRIG_W    (TRIG_W)
  ) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .enhanced   (enhanced),
    .dlabSet    (dlabSet),
    .anyTrigEn  (anyTrigEn),
    .irqEn      (irqEn),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .ctlRdData  (ctlRdData),
    .trigRegWr  (trigRegWr),
    .trigRegData(trigRegData),
    .wrValid    (wrValid),
    .popReq     (popReq),
    .level      (level),
    .strobe     (strobe),
    .full       (full),
    .empty      (empty),
    .irq        (irq)
  );

  txq_datapath #(
    .DATA_W   (DATA_W),
    .MAX_DEPTH(MAX_DEPTH)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .headData(popData),
    .count   (level)
  );

endmodule

// File: tb/test_tx_hold_queue.sv
`timescale 1ns/1ps
module test_tx_hold_queue;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       enhanced = 1'b0;
  logic       dlabSet = 1'b0;
  logic       anyTrigEn = 1'b0;
  logic       irqEn = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = 8'h00;
  logic [7:0] ctlRdData;
  logic       trigRegWr = 1'b0;
  logic [6:0] trigRegData = 7'd0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic [7:0] level;
  logic       full;
  logic       empty;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tx_hold_queue i_tx_hold_queue (
    .clk(clk), .rstN(rstN), .mode(mode), .enhanced(enhanced), .dlabSet(dlabSet),
    .anyTrigEn(anyTrigEn), .irqEn(irqEn), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .trigRegWr(trigRegWr), .trigRegData(trigRegData),
    .wrValid(wrValid), .wrData(wrData), .popReq(popReq), .popData(popData),
    .level(level), .full(full), .empty(empty), .irq(irq)
  );

  typedef struct packed {
    logic [2:0] vMode;
    logic       vEnh;
    logic [7:0] vCtl;
    logic       vDlab;
    logic       vAny;
    logic [6:0] vTrig;
    logic [7:0] expDepth;
    logic [7:0] expTrig;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 7'd0,  8'd1,   8'd1},   // R2 byte mode
    '{3'd1, 1'b0, 8'h01, 1'b0, 1'b0, 7'd0,  8'd16,  8'd1},   // R4
    '{3'd1, 1'b0, 8'h39, 1'b0, 1'b0, 7'd0,  8'd16,  8'd1},   // R9 field ignored
    '{3'd2, 1'b1, 8'h09, 1'b0, 1'b0, 7'd0,  8'd128, 8'd16},  // R8 R6
    '{3'd2, 1'b1, 8'h19, 1'b0, 1'b0, 7'd0,  8'd128, 8'd32},  // R8
    '{3'd2, 1'b1, 8'h29, 1'b0, 1'b0, 7'd0,  8'd128, 8'd64},  // R8
    '{3'd2, 1'b1, 8'h39, 1'b0, 1'b0, 7'd0,  8'd128, 8'd112}, // R8
    '{3'd2, 1'b1, 8'h31, 1'b0, 1'b0, 7'd0,  8'd128, 8'd1},   // R9 request mode 0
    '{3'd2, 1'b0, 8'h39, 1'b0, 1'b0, 7'd0,  8'd16,  8'd1},   // R9 not enhanced
    '{3'd3, 1'b0, 8'h21, 1'b1, 1'b0, 7'd0,  8'd128, 8'd1},   // R5 latch access set
    '{3'd3, 1'b0, 8'h21, 1'b0, 1'b0, 7'd0,  8'd16,  8'd1},   // R5 latch access clear
    '{3'd4, 1'b1, 8'h39, 1'b0, 1'b1, 7'd45, 8'd128, 8'd45},  // R10
    '{3'd4, 1'b1, 8'h01, 1'b0, 1'b0, 7'd45, 8'd128, 8'd1},   // R10 disabled -> R9
    '{3'd0, 1'b1, 8'h00, 1'b0, 1'b0, 7'd0,  8'd1,   8'd1}    // R2 enhanced, byte mode
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] m, input logic e);
    rstN = 1'b0; mode = m; enhanced = e; irqEn = 1'b0;
    anyTrigEn = 1'b0; dlabSet = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic wrCtl(input logic [7:0] d);
    ctlWrEn = 1'b1; ctlWrData = d;
    tick();
    ctlWrEn = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    wrValid = 1'b1; wrData = d;
    tick();
    wrValid = 1'b0;
  endtask

  task automatic pop();
    popReq = 1'b1;
    tick();
    popReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset(3'd1, 1'b0);
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ctlRd", ctlRdData, 0);

    // vector table: depth and threshold per configuration
    for (int v = 0; v < NVEC; v++) begin
      int fall;
      doReset(VECS[v].vMode, VECS[v].vEnh);
      if (VECS[v].vAny) begin
        anyTrigEn = 1'b1;
        trigRegWr = 1'b1; trigRegData = VECS[v].vTrig;
        tick();
        trigRegWr = 1'b0;
      end
      dlabSet = VECS[v].vDlab;
      wrCtl(VECS[v].vCtl);
      dlabSet = 1'b0;
      tick();
      irqEn = 1'b1;
      fall = -1;
      for (int i = 0; i < 130; i++) begin
        push(8'(i));
        if (!irq && fall < 0) fall = level;
      end
      chk($sformatf("R8/R9/R10 threshold vec%0d", v), fall, VECS[v].expTrig);
      chk($sformatf("R2/R4/R5/R6 depth vec%0d", v), level, VECS[v].expDepth);
      chk($sformatf("R2 full vec%0d", v), full, 1);
    end

    // R11 interrupt gating
    doReset(3'd1, 1'b0);
    wrCtl(8'h01); tick();
    chk("R11 irq disabled", irq, 0);
    irqEn = 1'b1; tick();
    chk("R11 irq enabled below threshold", irq, 1);
    push(8'h55);
    chk("R11 irq at threshold", irq, 0);
    irqEn = 1'b0;

    // R3 overflow discard and order
    doReset(3'd1, 1'b0);
    wrCtl(8'h01); tick();
    for (int i = 0; i < 16; i++) push(8'(i + 8'h10));
    chk("R3 full", full, 1);
    push(8'hEE);
    chk("R3 level unchanged", level, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R3 R12 data order", popData, i + 8'h10);
      pop();
    end
    chk("R3 drained", empty, 1);

    // R12 simultaneous push and pop
    push(8'hA1); push(8'hB2);
    wrValid = 1'b1; wrData = 8'hC3; popReq = 1'b1;
    tick();
    wrValid = 1'b0; popReq = 1'b0;
    chk("R12 level held", level, 2);
    chk("R12 head", popData, 8'hB2);
    pop();
    chk("R12 next", popData, 8'hC3);

    // R7 flush self-clear
    doReset(3'd1, 1'b0);
    wrCtl(8'h01); tick();
    for (int i = 0; i < 5; i++) push(8'(i));
    wrCtl(8'h05);
    chk("R7 flush pending readback", ctlRdData[2], 1);
    tick();
    chk("R7 flush bit cleared", ctlRdData[2], 0);
    chk("R7 level zero", level, 0);
    chk("R7 empty", empty, 1);
    chk("R7 enable kept", ctlRdData[0], 1);

    // R13 depth change empties the queue
    doReset(3'd3, 1'b0);
    wrCtl(8'h01); tick();
    for (int i = 0; i < 3; i++) push(8'(i));
    dlabSet = 1'b1;
    wrCtl(8'h21);
    dlabSet = 1'b0;
    tick();
    chk("R13 level after depth change", level, 0);
    chk("R5 deep bit readback", ctlRdData[5], 1);

    // R5 locked bit keeps value without latch access
    wrCtl(8'h01); tick();
    chk("R5 locked bit kept", ctlRdData[5], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule